// File: doc/BRIEF.md
# Trap Entry and Return Sequencer

This block is the multi-cycle controller a 32-bit processor core uses to enter an exception or interrupt handler and to come back from it. When the core raises an entry request, the sequencer saves the current program counter and both status words on the active stack. It then clears the processor status word and fetches a fresh program counter and system status word from a vector location. When the core raises a return request, the sequencer restores the three saved words from the stack, taking them in the opposite order.

All memory traffic goes through one word-wide request/acknowledge port, and every access waits for its acknowledge. The stack pointer lives in the core's register file. The block reads it through a port that selects either the user bank or the supervisor bank, depending on the mode bit of the current system status word. It writes the updated pointer back in the cycle that finishes the sequence. In that same cycle it also writes the program counter and both status words.

Top module: `trap_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `mem_req` and all register write strobes are low, and no memory request is issued while `busy` is low.
- R2: An entry request stores three words with descending addresses, each stack pointer update taking place before its store: program counter at SP-4, then processor status word at SP-8, then system status word at SP-12 (`mem_we`=1 for each).
- R3: Each memory access keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ack` is seen, and the sequence advances only on `mem_ack`.
- R4: After the three stores, an entry reads the new program counter from the vector address plus 0 and then the new system status word from the vector address plus 4 (`mem_we`=0).
- R5: `done` is high for exactly one cycle, the cycle after the last acknowledged access. In that cycle `pc_we`, `psw_we`, `ssw_we` and `sp_we` are all high. For an entry, `psw_out` is 0, `pc_out` and `ssw_out` hold the two vector words, and `sp_wdata` is SP-12.
- R6: A return request only reads: the system status word at SP, then the processor status word at SP+4, then the program counter at SP+8. At `done` these are presented on `ssw_out`, `psw_out` and `pc_out`, with `sp_wdata` = SP+12.
- R7: While idle, `sp_bank` equals bit `MODE_BIT` (default 2) of `cur_ssw`, with 1 meaning the user bank. It keeps the value latched at acceptance for the whole sequence, even if `cur_ssw` changes.
- R8: If both requests are high in the same idle cycle, the entry wins. Requests that arrive while a sequence is running are ignored and cause no later memory access.
- R9: `busy` rises in the cycle after a request is accepted and falls in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Request to enter a handler |
| rti_req | input | 1 | Request to return from a handler |
| vec_addr | input | 32 | Byte address of the handler vector |
| cur_pc | input | 32 | Current program counter |
| cur_psw | input | 32 | Current processor status word |
| cur_ssw | input | 32 | Current system status word |
| sp_bank | output | 1 | Stack pointer bank select (1 = user) |
| sp_rdata | input | 32 | Stack pointer of the selected bank |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_wdata | output | 32 | Updated stack pointer |
| pc_we | output | 1 | Program counter write strobe |
| pc_out | output | 32 | New program counter |
| psw_we | output | 1 | Processor status word write strobe |
| psw_out | output | 32 | New processor status word |
| ssw_we | output | 1 | System status word write strobe |
| ssw_out | output | 32 | New system status word |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Sequence in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory access acknowledge |

## Verification
The main sequences are tried with entries and returns from both banks. The bank that is not selected holds a different stack pointer, so a wrong bank shows up as a wrong address. The saved words use distinct values, including an all-ones status word, so a swapped or missing store is visible. The memory answers with zero, one and two cycles of wait, which separates an access that waits for its acknowledge from one that races ahead. Directed cases cover simultaneous requests, a request raised in the middle of a return, and a mode bit that flips while a sequence runs; these expose priority errors, lost ignores and an unlatched bank select.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int XLEN        = 32;
    localparam int WORD_BYTES  = XLEN / 8;
    localparam int FRAME_WORDS = 3;
    localparam int FRAME_BYTES = FRAME_WORDS * WORD_BYTES;

    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_PSW,
        ST_PUSH_SSW,
        ST_VEC_PC,
        ST_VEC_SSW,
        ST_POP_SSW,
        ST_POP_PSW,
        ST_POP_PC,
        ST_DONE
    } seq_state_t;

    typedef enum logic {
        K_ENTRY,
        K_RETURN
    } seq_kind_t;

    typedef struct packed {
        word_t pc;
        word_t psw;
        word_t ssw;
    } ctx_t;

    typedef struct packed {
        logic  req;
        logic  we;
        word_t addr;
        word_t wdata;
    } bus_cmd_t;

    function automatic logic is_access(seq_state_t s);
        return (s != ST_IDLE) && (s != ST_DONE);
    endfunction

    function automatic seq_state_t step_after(seq_state_t s);
        case (s)
            ST_PUSH_PC:  return ST_PUSH_PSW;
            ST_PUSH_PSW: return ST_PUSH_SSW;
            ST_PUSH_SSW: return ST_VEC_PC;
            ST_VEC_PC:   return ST_VEC_SSW;
            ST_VEC_SSW:  return ST_DONE;
            ST_POP_SSW:  return ST_POP_PSW;
            ST_POP_PSW:  return ST_POP_PC;
            ST_POP_PC:   return ST_DONE;
            default:     return ST_IDLE;
        endcase
    endfunction

    function automatic bus_cmd_t access_cmd(seq_state_t s, word_t sp, word_t vec, ctx_t c);
        bus_cmd_t r;
        r = '0;
        case (s)
            ST_PUSH_PC:  r = '{req: 1'b1, we: 1'b1, addr: sp - word_t'(1 * WORD_BYTES), wdata: c.pc};
            ST_PUSH_PSW: r = '{req: 1'b1, we: 1'b1, addr: sp - word_t'(2 * WORD_BYTES), wdata: c.psw};
            ST_PUSH_SSW: r = '{req: 1'b1, we: 1'b1, addr: sp - word_t'(3 * WORD_BYTES), wdata: c.ssw};
            ST_VEC_PC:   r = '{req: 1'b1, we: 1'b0, addr: vec, wdata: '0};
            ST_VEC_SSW:  r = '{req: 1'b1, we: 1'b0, addr: vec + word_t'(WORD_BYTES), wdata: '0};
            ST_POP_SSW:  r = '{req: 1'b1, we: 1'b0, addr: sp, wdata: '0};
            ST_POP_PSW:  r = '{req: 1'b1, we: 1'b0, addr: sp + word_t'(1 * WORD_BYTES), wdata: '0};
            ST_POP_PC:   r = '{req: 1'b1, we: 1'b0, addr: sp + word_t'(2 * WORD_BYTES), wdata: '0};
            default:     r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trap_req,
    input  logic       rti_req,
    input  logic       mem_ack,
    output seq_state_t state,
    output seq_kind_t  kind,
    output logic       start
);

    seq_state_t nxt;

    always_comb start = (state == ST_IDLE) && (trap_req || rti_req);

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: begin
                if (trap_req)     nxt = ST_PUSH_PC;
                else if (rti_req) nxt = ST_POP_SSW;
            end
            ST_DONE: nxt = ST_IDLE;
            default: if (mem_ack) nxt = step_after(state);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            kind  <= K_ENTRY;
        end else begin
            state <= nxt;
            if (start) kind <= trap_req ? K_ENTRY : K_RETURN;
        end
    end

    AST_WAIT_FOR_ACK: assert property (@(posedge clk) disable iff (rst)
        (is_access(state) && !mem_ack) |=> $stable(state)); // R3

    AST_ENTRY_WINS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && trap_req) |=> (state == ST_PUSH_PC && kind == K_ENTRY)); // R8

endmodule

// File: rtl/trap_regs.sv
module trap_regs
    import trap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  seq_state_t state,
    input  logic       mem_ack,
    input  word_t      mem_rdata,
    input  word_t      sp_in,
    input  word_t      vec_in,
    input  ctx_t       ctx_in,
    input  logic       bank_in,
    output word_t      sp_base,
    output word_t      vec_base,
    output ctx_t       ctx_snap,
    output ctx_t       ctx_new,
    output logic       bank_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_base  <= '0;
            vec_base <= '0;
            ctx_snap <= '0;
            ctx_new  <= '0;
            bank_q   <= 1'b0;
        end else if (start) begin
            sp_base  <= sp_in;
            vec_base <= vec_in;
            ctx_snap <= ctx_in;
            ctx_new  <= '0;
            bank_q   <= bank_in;
        end else if (mem_ack) begin
            case (state)
                ST_VEC_PC,  ST_POP_PC:  ctx_new.pc  <= mem_rdata;
                ST_VEC_SSW, ST_POP_SSW: ctx_new.ssw <= mem_rdata;
                ST_POP_PSW:             ctx_new.psw <= mem_rdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/trap_agu.sv
module trap_agu
    import trap_pkg::*;
(
    input  seq_state_t state,
    input  word_t      sp_base,
    input  word_t      vec_base,
    input  ctx_t       ctx_snap,
    output bus_cmd_t   cmd
);

    always_comb cmd = access_cmd(state, sp_base, vec_base, ctx_snap);

endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_pkg::*;
#(
    parameter int MODE_BIT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_req,
    input  logic            rti_req,
    input  logic [XLEN-1:0] vec_addr,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] cur_psw,
    input  logic [XLEN-1:0] cur_ssw,
    output logic            sp_bank,
    input  logic [XLEN-1:0] sp_rdata,
    output logic            sp_we,
    output logic [XLEN-1:0] sp_wdata,
    output logic            pc_we,
    output logic [XLEN-1:0] pc_out,
    output logic            psw_we,
    output logic [XLEN-1:0] psw_out,
    output logic            ssw_we,
    output logic [XLEN-1:0] ssw_out,
    output logic            done,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    input  logic            mem_ack
);

    seq_state_t state;
    seq_kind_t  kind;
    logic       start;
    word_t      sp_base, vec_base;
    ctx_t       ctx_snap, ctx_new, ctx_in;
    logic       bank_q;
    bus_cmd_t   cmd;

    always_comb ctx_in = '{pc: cur_pc, psw: cur_psw, ssw: cur_ssw};

    trap_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .trap_req (trap_req),
        .rti_req  (rti_req),
        .mem_ack  (mem_ack),
        .state    (state),
        .kind     (kind),
        .start    (start)
    );

    trap_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .state     (state),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .sp_in     (sp_rdata),
        .vec_in    (vec_addr),
        .ctx_in    (ctx_in),
        .bank_in   (cur_ssw[MODE_BIT]),
        .sp_base   (sp_base),
        .vec_base  (vec_base),
        .ctx_snap  (ctx_snap),
        .ctx_new   (ctx_new),
        .bank_q    (bank_q)
    );

    trap_agu u_agu (
        .state    (state),
        .sp_base  (sp_base),
        .vec_base (vec_base),
        .ctx_snap (ctx_snap),
        .cmd      (cmd)
    );

    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        sp_bank   = (state == ST_IDLE) ? cur_ssw[MODE_BIT] : bank_q;
        mem_req   = cmd.req;
        mem_we    = cmd.we;
        mem_addr  = cmd.addr;
        mem_wdata = cmd.wdata;
        pc_we     = done;
        psw_we    = done;
        ssw_we    = done;
        sp_we     = done;
        pc_out    = ctx_new.pc;
        psw_out   = ctx_new.psw;
        ssw_out   = ctx_new.ssw;
        sp_wdata  = (kind == K_ENTRY) ? sp_base - word_t'(FRAME_BYTES)
                                      : sp_base + word_t'(FRAME_BYTES);
    end

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R3

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req); // R1

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(mem_ack)); // R5

    AST_RETURN_READS_ONLY: assert property (@(posedge clk) disable iff (rst)
        (mem_req && kind == K_RETURN) |-> !mem_we); // R6

    AST_BANK_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(sp_bank)); // R7

endmodule

// File: tb/sim_trap_seq.sv
`timescale 1ns/1ps
module sim_trap_seq;

    localparam int MB = 2;

    typedef struct packed {
        logic        is_rti;
        logic        user;
        logic [31:0] sp;
        logic [31:0] vec;
        logic [31:0] pc;
        logic [31:0] psw;
        logic [31:0] ssw;
        logic [3:0]  lat;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b0, 1'b1, 32'h0000_1000, 32'h0000_0100, 32'h0040_1234, 32'h0000_00F3, 32'h8000_0000, 4'd0},
        '{1'b0, 1'b0, 32'h0000_2000, 32'h0000_0180, 32'h1234_5678, 32'hFFFF_FFFF, 32'h0000_0011, 4'd2},
        '{1'b1, 1'b1, 32'h0000_0FF4, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0020, 4'd1},
        '{1'b1, 1'b0, 32'h0000_1FF4, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0001, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_req = 1'b0, rti_req = 1'b0;
    logic [31:0] vec_addr = '0, cur_pc = '0, cur_psw = '0, cur_ssw = '0;
    logic        sp_bank, sp_we, pc_we, psw_we, ssw_we, done, busy, mem_req, mem_we;
    logic [31:0] sp_rdata, sp_wdata, pc_out, psw_out, ssw_out, mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [31:0] sp_user = '0, sp_sup = '0;

    always #2 clk = ~clk;

    assign sp_rdata = sp_bank ? sp_user : sp_sup;

    trap_seq #(.MODE_BIT(MB)) u0 (
        .clk(clk), .rst(rst), .trap_req(trap_req), .rti_req(rti_req),
        .vec_addr(vec_addr), .cur_pc(cur_pc), .cur_psw(cur_psw), .cur_ssw(cur_ssw),
        .sp_bank(sp_bank), .sp_rdata(sp_rdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
        .pc_we(pc_we), .pc_out(pc_out), .psw_we(psw_we), .psw_out(psw_out),
        .ssw_we(ssw_we), .ssw_out(ssw_out), .done(done), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int n_chk = 0, n_fail = 0;

    // memory model and monitor state
    logic [31:0] mem_arr [logic [31:0]];
    int          lat = 0, waitc = 0, neg_idx = 0, last_ack_idx = -10;
    int          log_n = 0, hold_err = 0, done_err = 0, done_cnt = 0, req_seen = 0;
    logic [31:0] log_addr [8];
    logic [31:0] log_wd [8];
    logic        log_we [8];
    logic        log_bank [8];
    logic [31:0] cap_pc, cap_psw, cap_ssw, cap_sp;
    logic        cap_we_all;
    logic        prev_pend = 1'b0, prev_done = 1'b0, p_we;
    logic [31:0] p_addr, p_wd;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            neg_idx++;
            if (mem_req) req_seen++;
            if (prev_pend && (!mem_req || mem_addr !== p_addr || mem_we !== p_we || mem_wdata !== p_wd))
                hold_err++;
            if (done) begin
                if (prev_done || neg_idx != last_ack_idx + 1) done_err++;
                cap_pc = pc_out; cap_psw = psw_out; cap_ssw = ssw_out; cap_sp = sp_wdata;
                cap_we_all = pc_we & psw_we & ssw_we & sp_we;
                done_cnt++;
            end
            prev_done = done;
            prev_pend = 1'b0;
            if (mem_ack) begin
                mem_ack = 1'b0;
                waitc = 0;
            end else if (mem_req) begin
                if (waitc >= lat) begin
                    if (log_n < 8) begin
                        log_addr[log_n] = mem_addr; log_we[log_n] = mem_we;
                        log_wd[log_n] = mem_wdata; log_bank[log_n] = sp_bank;
                    end
                    log_n++;
                    if (mem_we) mem_arr[mem_addr] = mem_wdata;
                    else mem_rdata = mem_arr.exists(mem_addr) ? mem_arr[mem_addr] : (32'hDEAD_0000 ^ mem_addr);
                    mem_ack = 1'b1;
                    last_ack_idx = neg_idx;
                end else begin
                    waitc++;
                    prev_pend = 1'b1; p_addr = mem_addr; p_we = mem_we; p_wd = mem_wdata;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    task automatic wait_done(input int d0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (done_cnt != d0) break;
        end
        @(negedge clk);
    endtask

    initial begin
        int d0;
        vec_t v;
        logic [31:0] e_addr [5];
        logic [31:0] e_wd [5];
        logic        e_we [5];
        logic [31:0] e_pc, e_psw, e_ssw, e_sp;
        int          e_n;
        logic        bank_ok;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {28'd0, busy, done, mem_req, sp_we}, 32'd0, "idle outputs in reset");
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1", {29'd0, busy, done, mem_req}, 32'd0, "idle outputs after reset");

        // R7 bank select follows mode bit while idle
        cur_ssw = 32'h0000_0004; #1;
        chk("R7", {31'd0, sp_bank}, 32'd1, "idle bank user");
        cur_ssw = 32'hFFFF_FFFB; #1;
        chk("R7", {31'd0, sp_bank}, 32'd0, "idle bank supervisor");

        // table-driven main sequences: R2 R4 R5 R6 R3 R9
        for (int k = 0; k < 4; k++) begin
            v = VECS[k];
            @(negedge clk);
            mem_arr.delete();
            lat = int'(v.lat); log_n = 0; hold_err = 0; done_err = 0;
            sp_user = v.user ? v.sp : (v.sp ^ 32'h0000_8000);
            sp_sup  = v.user ? (v.sp ^ 32'h0000_8000) : v.sp;
            vec_addr = v.vec; cur_pc = v.pc; cur_psw = v.psw;
            cur_ssw = v.user ? (v.ssw | 32'h4) : (v.ssw & ~32'h4);
            if (!v.is_rti) begin
                e_pc = {16'hC0DE, v.vec[15:0]}; e_ssw = {16'h5500, v.vec[15:0]}; e_psw = 32'h0;
                mem_arr[v.vec] = e_pc; mem_arr[v.vec + 32'd4] = e_ssw;
                e_sp = v.sp - 32'd12; e_n = 5;
                e_addr[0] = v.sp - 32'd4;  e_we[0] = 1'b1; e_wd[0] = v.pc;
                e_addr[1] = v.sp - 32'd8;  e_we[1] = 1'b1; e_wd[1] = v.psw;
                e_addr[2] = v.sp - 32'd12; e_we[2] = 1'b1; e_wd[2] = cur_ssw;
                e_addr[3] = v.vec;         e_we[3] = 1'b0; e_wd[3] = 32'h0;
                e_addr[4] = v.vec + 32'd4; e_we[4] = 1'b0; e_wd[4] = 32'h0;
            end else begin
                e_ssw = 32'h3300_0000 | v.sp; e_psw = 32'h2200_0000 | v.sp; e_pc = 32'h1100_0000 | v.sp;
                mem_arr[v.sp] = e_ssw; mem_arr[v.sp + 32'd4] = e_psw; mem_arr[v.sp + 32'd8] = e_pc;
                e_sp = v.sp + 32'd12; e_n = 3;
                e_addr[0] = v.sp;         e_we[0] = 1'b0; e_wd[0] = 32'h0;
                e_addr[1] = v.sp + 32'd4; e_we[1] = 1'b0; e_wd[1] = 32'h0;
                e_addr[2] = v.sp + 32'd8; e_we[2] = 1'b0; e_wd[2] = 32'h0;
            end
            d0 = done_cnt;
            if (v.is_rti) rti_req = 1'b1; else trap_req = 1'b1;
            @(negedge clk);
            trap_req = 1'b0; rti_req = 1'b0;
            chk("R9", {31'd0, busy}, 32'd1, "busy after accept");
            cur_ssw = cur_ssw ^ 32'h4; // flip mode mid-sequence: bank must hold (R7)
            wait_done(d0);
            chk("R9", {31'd0, busy}, 32'd0, "busy after done");
            chk("R5", done_cnt - d0, 32'd1, "one done pulse");
            chk("R5", done_err, 32'd0, "done timing and width");
            chk("R3", hold_err, 32'd0, "request held while waiting");
            chk(v.is_rti ? "R6" : "R2", log_n, e_n, "access count");
            bank_ok = 1'b1;
            for (int a = 0; a < e_n; a++) begin
                chk(v.is_rti ? "R6" : (a < 3 ? "R2" : "R4"), log_addr[a], e_addr[a], "access address");
                chk(v.is_rti ? "R6" : (a < 3 ? "R2" : "R4"), {31'd0, log_we[a]}, {31'd0, e_we[a]}, "access direction");
                if (e_we[a]) chk("R2", log_wd[a], e_wd[a], "stored word");
                if (log_bank[a] !== v.user) bank_ok = 1'b0;
            end
            chk("R7", {31'd0, bank_ok}, 32'd1, "bank held through sequence");
            chk(v.is_rti ? "R6" : "R5", cap_pc, e_pc, "new pc");
            chk(v.is_rti ? "R6" : "R5", cap_psw, e_psw, "new psw");
            chk(v.is_rti ? "R6" : "R5", cap_ssw, e_ssw, "new ssw");
            chk(v.is_rti ? "R6" : "R5", cap_sp, e_sp, "new stack pointer");
            chk("R5", {31'd0, cap_we_all}, 32'd1, "write strobes at done");
        end

        // R8 both requests together: entry wins
        @(negedge clk);
        lat = 0; log_n = 0; mem_arr.delete();
        cur_ssw = 32'h0; sp_sup = 32'h0000_3000; vec_addr = 32'h0000_0200;
        d0 = done_cnt;
        trap_req = 1'b1; rti_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0; rti_req = 1'b0;
        wait_done(d0);
        chk("R8", log_n, 32'd5, "entry chosen access count");
        chk("R8", {31'd0, log_we[0]}, 32'd1, "entry chosen first access writes");

        // R8 request during a running return is ignored
        @(negedge clk);
        lat = 0; log_n = 0; sp_sup = 32'h0000_3FF4;
        d0 = done_cnt;
        rti_req = 1'b1;
        @(negedge clk);
        rti_req = 1'b0;
        @(negedge clk);
        trap_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
        wait_done(d0);
        req_seen = 0;
        repeat (6) @(negedge clk);
        chk("R8", log_n, 32'd3, "only return accesses");
        chk("R8", req_seen, 32'd0, "no access after ignored request");
        chk("R1", {31'd0, busy}, 32'd0, "idle after ignored request");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule